// File: doc/BRIEF.md
# Programmable CRC-32 Register Engine

This block is a CRC-32 calculator that sits behind a small 32-bit register bus with per-byte write strobes. Software programs a seed and a full 32-bit generator polynomial. It then restarts the computation through a control bit and streams data into a single data register, either as whole 32-bit words or as single bytes. Each write advances the running checksum by the number of bits it carries. That checksum is updated in one clock and can be read back at any time.

The control register selects how incoming bits are reordered before they reach the engine. The options are no reordering, reordering within each byte, within each 16-bit half, or across the whole word. A separate control bit mirrors the checksum as it is read. With these controls one engine can produce both reflected and non-reflected checksums with any 32-bit polynomial, including the common CRC-32 and Castagnoli generators. A partial result can be read out, saved, and later written back as the seed to resume a stream. The engine itself works MSB-first with the polynomial in normal form. There is no state machine: every access completes in a single cycle.

Top module: `crc_eng`

## Requirements
- R1: After reset the seed register reads 0xFFFFFFFF, the polynomial register reads 0x04C11DB7, the control register reads 0 and the data register reads 0xFFFFFFFF.
- R2: A control write with bit 0 set loads the running checksum from the seed register at that clock edge. Bit 0 always reads back as 0. Writing the seed or polynomial register alone leaves the running checksum unchanged.
- R3: Control bits [6:5] (input order) and bit 7 (output mirror) are stored by a control write with strobe bit 0 set, including one that also restarts. A control write with bit 0 clear keeps the running checksum. Control bits [4:0] and [31:8] read as 0.
- R4: A data write with strobe 4'b1111 advances the checksum by 32 bits, MSB first, and the new value is readable in the cycle after the write. The checksum does not change without a data write or a restart.
- R5: A data write with strobe 4'b0001 advances the checksum by 8 bits, taken from write data bits [7:0] MSB first. Bits [31:8] are ignored.
- R6: A data write whose strobe is neither 4'b1111 nor 4'b0001 leaves the checksum unchanged.
- R7: Input order field: 2'b00 passes data unchanged, 2'b01 mirrors bits inside each byte, 2'b10 mirrors bits inside each 16-bit half, and 2'b11 mirrors all 32 bits. For a byte write, any non-zero value mirrors the 8 bits of that byte.
- R8: With control bit 7 set, a data-register read returns the running checksum with bit i moved to bit 31-i. With bit 7 clear, the value is returned unchanged.
- R9: The polynomial register is used as the full 32-bit generator on every update, so a newly programmed polynomial takes effect from the next data write.
- R10: A checksum read from the data register and written back as the seed, followed by a restart, continues the stream exactly as if it had never been interrupted.
- R11: Writes to the seed and polynomial registers update only the byte lanes whose strobe bit is set.
- R12: Word addresses 0 (data), 2 (control), 4 (seed) and 5 (polynomial) are mapped, at byte offsets 0x00, 0x08, 0x10 and 0x14. Reads of any other word address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write request for this cycle |
| bus_waddr | input | ADDR_W | Word address for both reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte-lane write strobes |
| bus_rdata | output | 32 | Read data for bus_waddr, combinational |

## Verification
Every write takes effect at the clock edge that samples it. Read data follows the address combinationally, so a checksum, control, seed or polynomial update is due one cycle after its write. The bench drives each write at a falling edge and lets the next rising edge capture it. It then changes the read address at the following falling edge and samples a nanosecond later, always after the result has registered and well away from the next edge. End-to-end results are compared against published check values for the nine-character string "123456789" and against a bit-serial model computed in the bench.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;

    localparam int CRC_W  = 32;
    localparam int BYTE_W = 8;
    localparam int LANES  = CRC_W / BYTE_W;

    // word addresses of the mapped registers
    localparam int unsigned IDX_DATA = 0;
    localparam int unsigned IDX_CTRL = 2;
    localparam int unsigned IDX_SEED = 4;
    localparam int unsigned IDX_POLY = 5;

    typedef enum logic [1:0] {
        ORD_PASS = 2'b00,
        ORD_BYTE = 2'b01,
        ORD_HALF = 2'b10,
        ORD_WORD = 2'b11
    } in_order_e;

    typedef struct packed {
        logic      out_mirror;
        in_order_e in_order;
    } ctrl_t;

    // Advance an MSB-first CRC by the low nbits of data, most significant first.
    function automatic logic [CRC_W-1:0] crc_advance(
        input logic [CRC_W-1:0] cur,
        input logic [CRC_W-1:0] data,
        input logic [CRC_W-1:0] poly,
        input int               nbits
    );
        logic [CRC_W-1:0] c;
        logic             fb;
        c = cur;
        for (int i = CRC_W - 1; i >= 0; i--) begin
            if (i < nbits) begin
                fb = c[CRC_W-1] ^ data[i];
                c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/crc_eng_regs.sv
module crc_eng_regs
    import crc_eng_pkg::*;
#(
    parameter int               ADDR_W   = 3,
    parameter logic [CRC_W-1:0] RST_SEED = 32'hFFFF_FFFF,
    parameter logic [CRC_W-1:0] RST_POLY = 32'h04C1_1DB7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [CRC_W-1:0]  wdata,
    input  logic [LANES-1:0]  wstrb,
    output ctrl_t             ctrl_q,
    output logic [CRC_W-1:0]  seed_q,
    output logic [CRC_W-1:0]  poly_q,
    output logic              restart,
    output logic              feed_word,
    output logic              feed_byte
);

    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(IDX_DATA);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(IDX_CTRL);
    localparam logic [ADDR_W-1:0] A_SEED = ADDR_W'(IDX_SEED);
    localparam logic [ADDR_W-1:0] A_POLY = ADDR_W'(IDX_POLY);

    logic             hit_data, hit_ctrl, hit_seed, hit_poly;
    logic [LANES-1:0] seed_we, poly_we;

    assign hit_data = wr && (waddr == A_DATA);
    assign hit_ctrl = wr && (waddr == A_CTRL) && wstrb[0];
    assign hit_seed = wr && (waddr == A_SEED);
    assign hit_poly = wr && (waddr == A_POLY);

    assign restart   = hit_ctrl && wdata[0];
    assign feed_word = hit_data && (wstrb == {LANES{1'b1}});
    assign feed_byte = hit_data && (wstrb == LANES'(1));

    for (genvar l = 0; l < LANES; l++) begin : g_lane_we
        assign seed_we[l] = hit_seed && wstrb[l];
        assign poly_we[l] = hit_poly && wstrb[l];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{out_mirror: 1'b0, in_order: ORD_PASS};
        end else if (hit_ctrl) begin
            ctrl_q.out_mirror <= wdata[7];
            ctrl_q.in_order   <= in_order_e'(wdata[6:5]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seed_q <= RST_SEED;
            poly_q <= RST_POLY;
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (seed_we[l]) seed_q[l*BYTE_W +: BYTE_W] <= wdata[l*BYTE_W +: BYTE_W];
                if (poly_we[l]) poly_q[l*BYTE_W +: BYTE_W] <= wdata[l*BYTE_W +: BYTE_W];
            end
        end
    end

endmodule

// File: rtl/crc_eng_inord.sv
module crc_eng_inord
    import crc_eng_pkg::*;
(
    input  logic [CRC_W-1:0] raw,
    input  in_order_e        order,
    input  logic             is_byte,
    output logic [CRC_W-1:0] feed
);

    localparam int HALF_W = CRC_W / 2;

    logic [CRC_W-1:0] mir_byte, mir_half, mir_word;

    for (genvar b = 0; b < CRC_W; b++) begin : g_mirror
        assign mir_byte[b] = raw[(b / BYTE_W) * BYTE_W + BYTE_W - 1 - (b % BYTE_W)];
        assign mir_half[b] = raw[(b / HALF_W) * HALF_W + HALF_W - 1 - (b % HALF_W)];
        assign mir_word[b] = raw[CRC_W - 1 - b];
    end

    always_comb begin
        feed = raw;
        if (is_byte) begin
            feed = {{(CRC_W-BYTE_W){1'b0}},
                    (order == ORD_PASS) ? raw[BYTE_W-1:0] : mir_byte[BYTE_W-1:0]};
        end else begin
            unique case (order)
                ORD_PASS: feed = raw;
                ORD_BYTE: feed = mir_byte;
                ORD_HALF: feed = mir_half;
                ORD_WORD: feed = mir_word;
                default:  feed = raw;
            endcase
        end
    end

endmodule

// File: rtl/crc_eng_core.sv
module crc_eng_core
    import crc_eng_pkg::*;
#(
    parameter logic [CRC_W-1:0] RST_SEED = 32'hFFFF_FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CRC_W-1:0] seed,
    input  logic             feed_word,
    input  logic             feed_byte,
    input  logic [CRC_W-1:0] feed,
    input  logic [CRC_W-1:0] poly,
    output logic [CRC_W-1:0] crc_q
);

    logic [CRC_W-1:0] next_word, next_byte;

    assign next_word = crc_advance(crc_q, feed, poly, CRC_W);
    assign next_byte = crc_advance(crc_q, feed, poly, BYTE_W);

    always_ff @(posedge clk) begin
        if (!rst_n)          crc_q <= RST_SEED;
        else if (restart)    crc_q <= seed;
        else if (feed_word)  crc_q <= next_word;
        else if (feed_byte)  crc_q <= next_byte;
    end

endmodule

// File: rtl/crc_eng.sv
module crc_eng
    import crc_eng_pkg::*;
#(
    parameter int               ADDR_W   = 3,
    parameter logic [CRC_W-1:0] RST_SEED = 32'hFFFF_FFFF,
    parameter logic [CRC_W-1:0] RST_POLY = 32'h04C1_1DB7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_waddr,
    input  logic [CRC_W-1:0]  bus_wdata,
    input  logic [LANES-1:0]  bus_wstrb,
    output logic [CRC_W-1:0]  bus_rdata
);

    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(IDX_DATA);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(IDX_CTRL);
    localparam logic [ADDR_W-1:0] A_SEED = ADDR_W'(IDX_SEED);
    localparam logic [ADDR_W-1:0] A_POLY = ADDR_W'(IDX_POLY);

    ctrl_t            ctrl_q;
    logic [CRC_W-1:0] seed_q, poly_q, crc_run, feed, crc_mir, crc_out;
    logic             restart, feed_word, feed_byte;

    crc_eng_regs #(
        .ADDR_W  (ADDR_W),
        .RST_SEED(RST_SEED),
        .RST_POLY(RST_POLY)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .waddr    (bus_waddr),
        .wdata    (bus_wdata),
        .wstrb    (bus_wstrb),
        .ctrl_q   (ctrl_q),
        .seed_q   (seed_q),
        .poly_q   (poly_q),
        .restart  (restart),
        .feed_word(feed_word),
        .feed_byte(feed_byte)
    );

    crc_eng_inord i_inord (
        .raw    (bus_wdata),
        .order  (ctrl_q.in_order),
        .is_byte(feed_byte),
        .feed   (feed)
    );

    crc_eng_core #(
        .RST_SEED(RST_SEED)
    ) i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .seed     (seed_q),
        .feed_word(feed_word),
        .feed_byte(feed_byte),
        .feed     (feed),
        .poly     (poly_q),
        .crc_q    (crc_run)
    );

    for (genvar b = 0; b < CRC_W; b++) begin : g_out_mirror
        assign crc_mir[b] = crc_run[CRC_W - 1 - b];
    end

    assign crc_out = ctrl_q.out_mirror ? crc_mir : crc_run;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_waddr)
            A_DATA:  bus_rdata = crc_out;
            A_CTRL:  bus_rdata = {{(CRC_W-8){1'b0}}, ctrl_q.out_mirror, ctrl_q.in_order, 5'b0};
            A_SEED:  bus_rdata = seed_q;
            A_POLY:  bus_rdata = poly_q;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/crc_eng_chk.sv
module crc_eng_chk
    import crc_eng_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_waddr,
    input logic [CRC_W-1:0]  bus_wdata,
    input logic [LANES-1:0]  bus_wstrb,
    input logic [CRC_W-1:0]  bus_rdata,
    input logic [CRC_W-1:0]  crc_run,
    input logic [CRC_W-1:0]  seed_q
);

    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(IDX_DATA);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(IDX_CTRL);
    localparam logic [ADDR_W-1:0] A_SEED = ADDR_W'(IDX_SEED);
    localparam logic [ADDR_W-1:0] A_POLY = ADDR_W'(IDX_POLY);

    logic is_restart, is_cfg, is_bad_feed, is_mapped;

    assign is_restart  = bus_wr && (bus_waddr == A_CTRL) && bus_wstrb[0] && bus_wdata[0];
    assign is_cfg      = bus_wr && ((bus_waddr == A_SEED) || (bus_waddr == A_POLY));
    assign is_bad_feed = bus_wr && (bus_waddr == A_DATA) &&
                         (bus_wstrb != {LANES{1'b1}}) && (bus_wstrb != LANES'(1));
    assign is_mapped   = (bus_waddr == A_DATA) || (bus_waddr == A_CTRL) ||
                         (bus_waddr == A_SEED) || (bus_waddr == A_POLY);

    // R2
    restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_restart |=> (crc_run == $past(seed_q)));

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_cfg |=> $stable(crc_run));

    // R6
    bad_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_bad_feed |=> $stable(crc_run));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(crc_run));

    // R3
    ctrl_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_waddr == A_CTRL) |-> (bus_rdata[4:0] == 5'b0 && bus_rdata[CRC_W-1:8] == '0));

    // R12
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_mapped |-> (bus_rdata == '0));

endmodule

bind crc_eng crc_eng_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata),
    .bus_wstrb(bus_wstrb),
    .bus_rdata(bus_rdata),
    .crc_run  (crc_run),
    .seed_q   (seed_q)
);

// File: tb/test_crc_eng.sv
module test_crc_eng;

    localparam logic [2:0] A_DATA = 3'd0;
    localparam logic [2:0] A_CTRL = 3'd2;
    localparam logic [2:0] A_SEED = 3'd4;
    localparam logic [2:0] A_POLY = 3'd5;
    localparam logic [31:0] P_STD  = 32'h04C1_1DB7;
    localparam logic [31:0] P_CAST = 32'h1EDC_6F41;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_waddr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_wstrb = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    crc_eng i_crc_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata),
        .bus_wstrb(bus_wstrb),
        .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] m_step(input logic [31:0] c, input logic [31:0] d,
                                           input int n, input logic [31:0] p);
        logic [31:0] r;
        r = c;
        for (int k = n - 1; k >= 0; k--) begin
            if (r[31] ^ d[k]) r = (r << 1) ^ p;
            else              r = r << 1;
        end
        return r;
    endfunction

    function automatic logic [31:0] m_mirror(input logic [31:0] v, input int unit);
        logic [31:0] r;
        for (int k = 0; k < 32; k++) r[(k / unit) * unit + unit - 1 - (k % unit)] = v[k];
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        bus_wr = 1'b1; bus_waddr = a; bus_wdata = d; bus_wstrb = s;
        @(negedge clk);
        bus_wr = 1'b0; bus_wstrb = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        bus_waddr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic restart(input logic [7:0] ctl);
        wr(A_CTRL, {24'b0, ctl | 8'h01}, 4'h1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_SEED, v); chk("R1 seed", v, 32'hFFFF_FFFF);
        rd(A_POLY, v); chk("R1 poly", v, P_STD);
        rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
        rd(A_DATA, v); chk("R1 data", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_map();
        logic [31:0] v;
        for (int a = 0; a < 8; a++) begin
            if (a == 1 || a == 3 || a == 6 || a == 7) begin
                rd(3'(a), v); chk("R12 unmapped", v, 32'h0);
            end
        end
    endtask

    task automatic t_plain_words();
        logic [31:0] v;
        restart(8'h00);
        wr(A_DATA, 32'h3132_3334, 4'hF);
        rd(A_DATA, v); chk("R4 first word", v, m_step(32'hFFFF_FFFF, 32'h3132_3334, 32, P_STD));
        wr(A_DATA, 32'h3536_3738, 4'hF);
        wr(A_DATA, 32'hAAAA_AA39, 4'h1);
        rd(A_DATA, v); chk("R5 plain check value", v, 32'h0376_E6E7);
        wr(A_CTRL, 32'h0000_0080, 4'h1);
        rd(A_DATA, v); chk("R8 mirrored read", v, m_mirror(32'h0376_E6E7, 32));
        rd(A_CTRL, v); chk("R3 ctrl no restart", v, 32'h80);
    endtask

    task automatic t_word_mirror();
        logic [31:0] v;
        restart(8'hE0);
        rd(A_CTRL, v); chk("R3 ctrl readback", v, 32'hE0);
        rd(A_DATA, v); chk("R2 restart load", v, 32'hFFFF_FFFF);
        wr(A_DATA, 32'h3433_3231, 4'hF);
        wr(A_DATA, 32'h3837_3635, 4'hF);
        wr(A_CTRL, 32'h0000_00A0, 4'h1);
        wr(A_DATA, 32'h0000_0039, 4'h1);
        rd(A_DATA, v); chk("R7 word order reflected", v, 32'h340B_C6D9);
    endtask

    task automatic t_byte_order();
        logic [31:0] v;
        restart(8'hA0);
        wr(A_DATA, 32'h3132_3334, 4'hF);
        wr(A_DATA, 32'h3536_3738, 4'hF);
        wr(A_DATA, 32'h0000_0039, 4'h1);
        rd(A_DATA, v); chk("R7 byte order reflected", v, 32'h340B_C6D9);
    endtask

    task automatic t_half_order();
        logic [31:0] v;
        restart(8'h40);
        wr(A_DATA, 32'h1234_5678, 4'hF);
        rd(A_DATA, v);
        chk("R7 half order", v, m_step(32'hFFFF_FFFF, m_mirror(32'h1234_5678, 16), 32, P_STD));
        wr(A_CTRL, 32'h0000_0060, 4'h1);
        wr(A_DATA, 32'h0000_00C5, 4'h1);
        chk("R7 word order byte feed", (rd_now()),
            m_step(m_step(32'hFFFF_FFFF, m_mirror(32'h1234_5678, 16), 32, P_STD),
                   32'h0000_00A3, 8, P_STD));
    endtask

    function automatic logic [31:0] rd_now();
        return bus_rdata;
    endfunction

    task automatic t_castagnoli();
        logic [31:0] v;
        wr(A_POLY, P_CAST, 4'hF);
        rd(A_DATA, v); v = v;
        restart(8'hA0);
        for (int k = 0; k < 9; k++) wr(A_DATA, 32'h31 + 32'(k), 4'h1);
        rd(A_DATA, v); chk("R9 castagnoli", v, 32'h1CF9_6D7C);
        wr(A_POLY, P_STD, 4'hF);
    endtask

    task automatic t_strobes();
        logic [31:0] v;
        restart(8'h00);
        wr(A_DATA, 32'h1111_2222, 4'h3);
        wr(A_DATA, 32'h1111_2222, 4'h2);
        wr(A_DATA, 32'h1111_2222, 4'h0);
        rd(A_DATA, v); chk("R6 bad strobes ignored", v, 32'hFFFF_FFFF);
        wr(A_SEED, 32'h0000_0000, 4'hF);
        rd(A_DATA, v); chk("R2 seed write no load", v, 32'hFFFF_FFFF);
        wr(A_SEED, 32'hFFFF_FFFF, 4'hF);
    endtask

    task automatic t_lanes();
        logic [31:0] v;
        wr(A_SEED, 32'h0000_AB00, 4'h2);
        rd(A_SEED, v); chk("R11 seed lane", v, 32'hFFFF_ABFF);
        wr(A_POLY, 32'h5500_0000, 4'h8);
        rd(A_POLY, v); chk("R11 poly lane", v, 32'h55C1_1DB7);
        wr(A_POLY, P_STD, 4'hF);
        wr(A_SEED, 32'hFFFF_FFFF, 4'hF);
    endtask

    task automatic t_save_restore();
        logic [31:0] part, v;
        restart(8'h00);
        wr(A_DATA, 32'h3132_3334, 4'hF);
        rd(A_DATA, part);
        restart(8'h00);
        wr(A_DATA, 32'hDEAD_BEEF, 4'hF);
        wr(A_SEED, part, 4'hF);
        restart(8'h00);
        wr(A_DATA, 32'h3536_3738, 4'hF);
        wr(A_DATA, 32'h0000_0039, 4'h1);
        rd(A_DATA, v); chk("R10 resumed stream", v, 32'h0376_E6E7);
        wr(A_SEED, 32'hFFFF_FFFF, 4'hF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_plain_words();
        t_word_mirror();
        t_byte_order();
        t_half_order();
        t_castagnoli();
        t_strobes();
        t_lanes();
        t_save_restore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual %08h expected %08h", 32'h0, 32'h1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule